// File: doc/BRIEF.md
# Pointer Signing and Authentication Unit

This unit protects 64-bit pointers by putting a keyed tag into the upper bits that a real pointer never uses. A client hands it one request at a time: an operation, a key selector, a pointer and a 64-bit modifier. The modifier is a context value, for example the address where the pointer is stored, or zero. The unit mixes the low address field of the pointer with the modifier and the selected 128-bit key over a fixed number of rounds. It then does one of three things. It writes the tag over the upper bits (sign). It checks the tag and strips it (authenticate). Or it returns the tag as a generic MAC.

Five keys are held: two for code pointers, two for data pointers and one for generic MACs. Software writes them through a port that can only write. No output ever shows a key. A failed check does not raise an exception. It returns the address with one high bit set, so the pointer is non-canonical and any later use of it faults. The mixing function is a light add-rotate-xor stand-in for a real block cipher.

The control state machine has three states:
- `ST_IDLE`: ready for a request.
- `ST_MIX`: the rounds are running.
- `ST_RESP`: the result is presented for one cycle.

Its transitions are:
- `ST_IDLE` to `ST_MIX` on accept.
- `ST_MIX` to `ST_RESP` when the mixer applies its last round.
- `ST_RESP` to `ST_IDLE` unconditionally.

Top module: `ptrauth_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Requests are handled one at a time.
  - A request is taken when `req_valid` and `req_ready` are both high at a rising edge.
  - `req_ready` is then 0 until the response has been given.
  - Each request gets exactly one response, in order, and `rsp_valid` stays high for one cycle.
- R3: Key slot codes are 0 for IA, 1 for IB, 2 for DA, 3 for DB and 4 for GA. A write to slots 0 to 4 stores `key_data`. A write to codes 5 to 7 has no effect, and requests that select codes 5 to 7 use an all-zero key.
- R4: The tag function works as follows.
  - The state starts as s = X ^ modifier.
  - For r = 0 to ROUNDS-1 (default 6): t = s + Kr + r, then s = rotl64(t,13) ^ (t >> 9). Kr is key[63:0] for even r and key[127:64] for odd r.
  - The 32-bit tag is s[63:32] ^ s[31:0].
  - X is the pointer with bits [63:VA_BITS] cleared for sign and authenticate, and the whole pointer for MAC.
- R5: Sign (op 0) of a pointer whose bits [63:VA_BITS] are zero returns the address bits [VA_BITS-1:0] unchanged, with bits [63:VA_BITS] equal to the low 64-VA_BITS tag bits. VA_BITS defaults to 39 and may be set to 48.
- R6: Sign of a pointer with any nonzero bit above VA_BITS returns the same result as R5, except that bit VA_BITS (the lowest signature bit) is inverted. Authenticating that result therefore fails.
- R7: Authenticate (op 1) returns the address with zeros above it when bits [63:VA_BITS] equal the signature that R5 would compute.
- R8: Authenticate with a mismatching signature, modifier or key returns the address with zeros above it, except for bit 62, which is set.
- R9: MAC (op 2, and reserved op 3) returns the tag in bits [63:32] and zero in bits [31:0].
- R10: The key is captured when the request is accepted. A key write while an operation is in flight does not change that operation's result.
- R11: A key write takes effect for the next request that is accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_we | input | 1 | Key write strobe |
| key_sel | input | 3 | Key slot to write |
| key_data | input | 128 | Key value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 0 sign, 1 authenticate, 2 or 3 MAC |
| req_key | input | 3 | Key slot used by the request |
| req_ptr | input | 64 | Pointer operand |
| req_mod | input | 64 | Context modifier |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_data | output | 64 | Result |

## Verification
The bench signs the same address under several modifiers and several keys. This shows that both the context and the key reach the tag, and that no key slot is aliased to another. Authentication is then tried four ways:
- with an intact signature, which must restore the canonical address;
- with one flipped signature bit;
- with a wrong modifier;
- with a wrong key.

The last three must each give the error-bit pattern. A non-canonical pointer is signed and then authenticated, which separates the deliberate signature corruption from an ordinary sign. The remaining cases are a write to an unused key code, a key rewrite during an operation, and the reserved op code. Together they tell capture-at-accept apart from live key use, and ignored writes apart from stored ones.

// File: rtl/ptrauth_pkg.sv
package ptrauth_pkg;

    typedef enum logic [1:0] {
        OP_SIGN = 2'd0,
        OP_AUTH = 2'd1,
        OP_MAC  = 2'd2,
        OP_RSVD = 2'd3
    } pa_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MIX  = 2'd1,
        ST_RESP = 2'd2
    } pa_state_e;

    // One add-rotate-xor round of the stand-in keyed mixer.
    function automatic logic [63:0] mix_round(input logic [63:0] s,
                                              input logic [63:0] kw,
                                              input logic [63:0] idx);
        logic [63:0] t;
        t = s + kw + idx;
        return {t[50:0], t[63:51]} ^ (t >> 9);
    endfunction

endpackage

// File: rtl/ptrauth_keys.sv
module ptrauth_keys #(
    parameter int NKEY  = 5,
    parameter int KEY_W = 128,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [KEY_W-1:0] rd_key
);
    logic [KEY_W-1:0] slot [NKEY];

    for (genvar g = 0; g < NKEY; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                slot[g] <= wr_key;
        end
    end

    // Unused selector codes read as an all-zero key.
    always_comb begin
        rd_key = '0;
        for (int i = 0; i < NKEY; i++)
            if (rd_sel == SEL_W'(i))
                rd_key = slot[i];
    end

endmodule

// File: rtl/ptrauth_mix.sv
module ptrauth_mix
    import ptrauth_pkg::*;
#(
    parameter int ROUNDS = 6,
    parameter int KEY_W  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [63:0]      seed,
    input  logic [KEY_W-1:0] key_in,
    output logic             last,
    output logic [63:0]      mixed
);
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int HALF  = KEY_W / 2;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [KEY_W-1:0] key_q;
    logic [63:0]      st_q;
    logic [63:0]      kword;

    assign kword = cnt[0] ? 64'(key_q[KEY_W-1:HALF]) : 64'(key_q[HALF-1:0]);
    assign last  = busy && (cnt == CNT_W'(ROUNDS - 1));
    assign mixed = st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            key_q <= '0;
            st_q  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt   <= '0;
            key_q <= key_in;
            st_q  <= seed;
        end else if (busy) begin
            st_q <= mix_round(st_q, kword, 64'(cnt));
            cnt  <= cnt + 1'b1;
            if (last)
                busy <= 1'b0;
        end
    end

    // R4: the mixed value only moves while rounds run or on a load
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(st_q));

endmodule

// File: rtl/ptrauth_unit.sv
module ptrauth_unit
    import ptrauth_pkg::*;
#(
    parameter int VA_BITS = 39,
    parameter int ROUNDS  = 6,
    parameter int ERR_BIT = 62
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_we,
    input  logic [2:0]   key_sel,
    input  logic [127:0] key_data,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [1:0]   req_op,
    input  logic [2:0]   req_key,
    input  logic [63:0]  req_ptr,
    input  logic [63:0]  req_mod,
    output logic         rsp_valid,
    output logic [63:0]  rsp_data
);
    localparam int SIG_W = 64 - VA_BITS;

    pa_state_e    state, state_nx;
    pa_op_e       op_q;
    logic [63:0]  ptr_q;
    logic [127:0] sel_key;
    logic [63:0]  seed;
    logic [63:0]  mixed;
    logic         mix_last;
    logic         accept;
    logic [31:0]  tag;
    logic [SIG_W-1:0] sig;
    logic         canon;

    assign accept = req_valid && req_ready;
    assign seed   = ((req_op == OP_SIGN || req_op == OP_AUTH)
                    ? {{SIG_W{1'b0}}, req_ptr[VA_BITS-1:0]} : req_ptr) ^ req_mod;

    ptrauth_keys #(.NKEY(5), .KEY_W(128), .SEL_W(3)) u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (key_we),
        .wr_sel (key_sel),
        .wr_key (key_data),
        .rd_sel (req_key),
        .rd_key (sel_key)
    );

    ptrauth_mix #(.ROUNDS(ROUNDS), .KEY_W(128)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .seed   (seed),
        .key_in (sel_key),
        .last   (mix_last),
        .mixed  (mixed)
    );

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_SIGN;
            ptr_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q  <= pa_op_e'(req_op);
                ptr_q <= req_ptr;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nx = ST_MIX;
            ST_MIX:  if (mix_last) state_nx = ST_RESP;
            ST_RESP:               state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    assign tag   = mixed[63:32] ^ mixed[31:0];
    assign sig   = tag[SIG_W-1:0];
    assign canon = (ptr_q[63:VA_BITS] == '0);

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_data  = '0;
        unique case (op_q)
            OP_SIGN: begin
                rsp_data[VA_BITS-1:0] = ptr_q[VA_BITS-1:0];
                rsp_data[63:VA_BITS]  = canon ? sig : (sig ^ SIG_W'(1));
            end
            OP_AUTH: begin
                rsp_data[VA_BITS-1:0] = ptr_q[VA_BITS-1:0];
                rsp_data[ERR_BIT]     = (ptr_q[63:VA_BITS] != sig);
            end
            OP_MAC, OP_RSVD: rsp_data = {tag, 32'h0};
            default:         rsp_data = '0;
        endcase
    end

    // R2: no second request is taken while one is in flight
    p_one_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2: the response is a single-cycle pulse
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: sign and authenticate never alter the address field
    p_addr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q inside {OP_SIGN, OP_AUTH})
        |-> rsp_data[VA_BITS-1:0] == ptr_q[VA_BITS-1:0]);

    // R8: an authenticated result has at most one bit set above the address
    p_auth_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == OP_AUTH) |-> $countones(rsp_data[63:VA_BITS]) <= 1);

    // R9: the MAC leaves its low half zero
    p_mac_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q inside {OP_MAC, OP_RSVD}) |-> rsp_data[31:0] == 32'h0);

endmodule

// File: tb/test_ptrauth_unit.sv
module test_ptrauth_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VA   = 39;
    localparam int NRND = 6;
    localparam int SW   = 64 - VA;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_we = 1'b0;
    logic [2:0]   key_sel = '0;
    logic [127:0] key_data = '0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = '0;
    logic [2:0]   req_key = '0;
    logic [63:0]  req_ptr = '0;
    logic [63:0]  req_mod = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_data;

    int checks = 0;
    int errors = 0;
    logic [127:0] bk [8];
    logic [63:0]  exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptrauth_unit #(.VA_BITS(VA), .ROUNDS(NRND), .ERR_BIT(62)) i_ptrauth_unit (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_sel(key_sel),
        .key_data(key_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_key(req_key), .req_ptr(req_ptr),
        .req_mod(req_mod), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] m_tag(input logic [63:0] x, input logic [127:0] k);
        logic [63:0] s, t;
        s = x;
        for (int r = 0; r < NRND; r++) begin
            t = s + ((r % 2 == 0) ? k[63:0] : k[127:64]) + 64'(r);
            s = {t[50:0], t[63:51]} ^ (t >> 9);
        end
        return s[63:32] ^ s[31:0];
    endfunction

    function automatic logic [63:0] m_addr(input logic [63:0] p);
        logic [63:0] a;
        a = '0;
        a[VA-1:0] = p[VA-1:0];
        return a;
    endfunction

    function automatic logic [63:0] m_sign(input logic [63:0] p, m, input logic [127:0] k);
        logic [31:0] t;
        logic [63:0] r;
        t = m_tag(m_addr(p) ^ m, k);
        r = m_addr(p);
        r[63:VA] = t[SW-1:0];
        if (p[63:VA] != '0) r[VA] = ~r[VA];
        return r;
    endfunction

    function automatic logic [63:0] m_auth(input logic [63:0] p, m, input logic [127:0] k);
        logic [31:0] t;
        logic [63:0] r;
        t = m_tag(m_addr(p) ^ m, k);
        r = m_addr(p);
        if (p[63:VA] != t[SW-1:0]) r[62] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr_key(input logic [2:0] s, input logic [127:0] v);
        @(negedge clk);
        key_we = 1'b1; key_sel = s; key_data = v;
        @(negedge clk);
        key_we = 1'b0;
        if (s < 3'd5) bk[s] = v;
    endtask

    // Driver: predicts, pushes, then returns once the request is accepted.
    task automatic send(input logic [1:0] op, input logic [2:0] ks,
                        input logic [63:0] p, m, input string rq);
        logic [63:0] e;
        case (op)
            2'd0:    e = m_sign(p, m, bk[ks]);
            2'd1:    e = m_auth(p, m, bk[ks]);
            default: e = {m_tag(p ^ m, bk[ks]), 32'h0};
        endcase
        exp_q.push_back(e);
        tag_q.push_back(rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_key = ks; req_ptr = p; req_mod = m;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low in flight", 64'(req_ready), 64'h0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", rsp_data, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_data === e, t, rsp_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pa, s1, s2;
        for (int i = 0; i < 8; i++) bk[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset state",
              {62'h0, req_ready, rsp_valid}, 64'h2);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset release",
              {62'h0, req_ready, rsp_valid}, 64'h2);

        wr_key(3'd0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
        wr_key(3'd1, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        wr_key(3'd2, 128'hdead_beef_cafe_f00d_0bad_c0de_1234_5678);
        wr_key(3'd3, 128'h0f0f_0f0f_f0f0_f0f0_aaaa_5555_3c3c_c3c3);
        wr_key(3'd4, 128'h9e37_79b9_7f4a_7c15_f39c_c060_5cdb_8543);

        pa = 64'h0000_0012_3456_7890;
        send(2'd0, 3'd0, pa, 64'h0, "R5 sign IA mod 0");
        send(2'd0, 3'd0, pa, 64'h0000_7fff_0000_1000, "R5 sign IA storage mod");
        send(2'd0, 3'd1, pa, 64'h0, "R3 sign IB");
        send(2'd0, 3'd2, pa, 64'h55, "R3 sign DA");
        send(2'd0, 3'd3, 64'h0000_007f_ffff_fff8, 64'h1, "R4 sign DB max address");

        s1 = m_sign(pa, 64'h42, bk[0]);
        send(2'd0, 3'd0, pa, 64'h42, "R5 sign for auth");
        send(2'd1, 3'd0, s1, 64'h42, "R7 auth match");
        send(2'd1, 3'd0, s1 ^ (64'h1 << 50), 64'h42, "R8 auth flipped sig bit");
        send(2'd1, 3'd0, s1, 64'h43, "R8 auth wrong modifier");
        send(2'd1, 3'd1, s1, 64'h42, "R8 auth wrong key");

        s2 = m_sign(pa | (64'h1 << 60), 64'h42, bk[0]);
        send(2'd0, 3'd0, pa | (64'h1 << 60), 64'h42, "R6 sign non-canonical");
        send(2'd1, 3'd0, s2, 64'h42, "R6 auth of corrupted sign fails");

        send(2'd2, 3'd4, 64'hffff_0000_1234_abcd, 64'h77, "R9 MAC GA");
        send(2'd3, 3'd4, 64'h0000_0000_0000_0001, 64'h0, "R9 reserved op as MAC");

        wr_key(3'd5, 128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff);
        send(2'd0, 3'd5, pa, 64'h9, "R3 unused slot write ignored, zero key");

        send(2'd0, 3'd0, pa, 64'h3, "R10 key captured at accept");
        wr_key(3'd0, 128'h5a5a_5a5a_a5a5_a5a5_1357_9bdf_2468_ace0);
        send(2'd0, 3'd0, pa, 64'h3, "R11 new key used next");
        send(2'd1, 3'd0, s1, 64'h42, "R11 old signature fails under new key");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule